// File: doc/BRIEF.md
# Segmented Address Translation Buffer

This block turns a 32-bit virtual address into a physical address for one access. The address space is first cut into fixed segments by the top three address bits. Some segments pass the address straight through and fix the cacheability. The others are looked up in a small, fully associative table of translation entries. Each entry carries its own page size, address-space tag, global flag and permission code. The result of a lookup is registered and appears one cycle later as a status, a physical address and a cacheable flag.

Software manages the table through two write ports. The control port sets the enable, the shared-memory mode, the sticky not-found flag, the lockdown amount and the replacement pointer, and it also fires a one-shot invalidate of every entry. The refill port loads a pair of entry words into the slot named by the replacement pointer. The pointer then advances and wraps back to the lockdown amount, so the slots below that amount stay fixed.

Top module: `segTlb`

## Requirements
- R1: In privileged mode, addresses with top bits 100, 101 or 111 are not translated. The result is hit (status 0) with the physical address equal to the virtual address, and cacheable is 1 only for 100.
- R2: In unprivileged mode, any address with bit 31 set gives access error (status 2), with physical address 0 and cacheable 0.
- R3: When the enable bit (control bit 0) is clear, an access to a translated region (bit 31 clear, or top bits 110) is a hit, with the address passed through unchanged and cacheable set to 1.
- R4: An entry matches when all of the following hold: its valid bit (high word bit 9) is set; its page number (high word 31:10) equals the address outside the page offset; its global bit (low word bit 8) is set, or its tag (high word 7:0) equals the current tag, or shared mode (control bit 1) is on; and its instruction bit (high word bit 8) is 1 for execute accesses and 0 for read or write. Access codes are read 0, write 1 and execute 2.
- R5: The page size field (low word 3:2) sets the offset width: 0 gives 10 bits, 1 gives 12, 2 gives 16 and 3 gives 20. On a hit, the physical address is the frame number (low word 31:10) above the offset joined with the virtual offset, and cacheable is low word bit 9.
- R6: A translated, enabled lookup that matches no entry reports miss (status 1) and sets the not-found flag (control bit 3). The flag stays set until a control write loads it.
- R7: In privileged mode, the permission code (low word 6:4) always allows read. Code bit 1 allows write and code bit 0 allows execute. A denied access reports permission fault (status 3).
- R8: In unprivileged mode, permission codes 0 to 3 deny every access. With code bit 2 set, read is allowed, bit 1 allows write and bit 0 allows execute.
- R9: A permitted write that hits an entry whose dirty bit (low word bit 1) is clear reports dirty fault (status 4). Every non-hit result gives physical address 0 and cacheable 0.
- R10: A refill writes the slot given by the replacement pointer (control 21:16). The pointer then advances by one, and after the last slot it wraps to the lockdown amount (control 13:8), so slots below that amount are never replaced. A control write loads the pointer directly.
- R11: Writing control bit 2 clears every valid bit and sets the pointer to the lockdown amount written in the same cycle. The bit always reads back as 0. A refill in the same cycle is dropped.
- R12: A lookup presented in one cycle produces its result after the next clock edge, with rsValid high. A lookup in the same cycle as a refill sees the table as it was before that refill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctlWe | input | 1 | Control register write strobe |
| ctlWdata | input | 32 | Control write value |
| ctlRdata | output | 32 | Control register read value |
| refWe | input | 1 | Refill strobe |
| refHi | input | 32 | Entry high word: page number, valid, instruction, tag |
| refLo | input | 32 | Entry low word: frame, attributes, permissions, size |
| lkValid | input | 1 | Lookup request |
| lkVaddr | input | 32 | Virtual address |
| lkAccess | input | 2 | Access type: 0 read, 1 write, 2 execute |
| lkPriv | input | 1 | Privileged access |
| curAsid | input | 8 | Current address-space tag |
| rsValid | output | 1 | Result valid |
| rsStatus | output | 3 | 0 hit, 1 miss, 2 access error, 3 permission, 4 dirty |
| rsPaddr | output | 32 | Physical address |
| rsCacheable | output | 1 | Cacheable attribute |

## Verification
Two functions can land in the same cycle. The first pair is a lookup and a refill of the entry that lookup needs. The bench drives both on one clock and expects a miss, then repeats the lookup alone and expects a hit. The second pair is an invalidate and a refill driven together. The bench then expects the refilled address to miss and the pointer to read back as the lockdown amount.

// File: rtl/segTlbPkg.sv
package segTlbPkg;
  localparam logic [1:0] ACC_READ  = 2'd0;
  localparam logic [1:0] ACC_WRITE = 2'd1;
  localparam logic [1:0] ACC_EXEC  = 2'd2;

  localparam logic [2:0] RES_HIT    = 3'd0;
  localparam logic [2:0] RES_MISS   = 3'd1;
  localparam logic [2:0] RES_ACCERR = 3'd2;
  localparam logic [2:0] RES_PERM   = 3'd3;
  localparam logic [2:0] RES_DIRTY  = 3'd4;

  localparam int FLD_W = 6;

  typedef struct packed {
    logic        invAll;
    logic        refill;
    logic        xlateEn;
    logic        sharedVm;
  } ctlStrobe_t;

  typedef struct packed {
    logic [21:0] vpn;
    logic        valid;
    logic        instr;
    logic [7:0]  asid;
    logic [21:0] pfn;
    logic        cach;
    logic        glob;
    logic [2:0]  ap;
    logic [1:0]  sz;
    logic        dirty;
  } tlbEntry_t;

  function automatic logic [31:0] offMask(input logic [1:0] sz);
    case (sz)
      2'd0:    return 32'h0000_03FF;
      2'd1:    return 32'h0000_0FFF;
      2'd2:    return 32'h0000_FFFF;
      default: return 32'h000F_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/segTlbCtrl.sv
module segTlbCtrl
  import segTlbPkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ctlWe,
  input  logic [31:0]      ctlWdata,
  input  logic             refWe,
  input  logic             missSeen,
  output ctlStrobe_t       strobe,
  output logic [IDX_W-1:0] wrIdx,
  output logic [31:0]      ctlRdata
);
  localparam logic [FLD_W-1:0] LAST_SLOT = FLD_W'(ENTRIES - 1);
  localparam logic [FLD_W-1:0] NUM_SLOTS = FLD_W'(ENTRIES);

  logic             enQ, sharedQ, nfQ;
  logic [FLD_W-1:0] lockQ, ptrQ, ptrNext, wrLock, wrPtr;
  logic             invNow, ptrInRange;
  logic             unusedBits;

  assign wrLock     = ctlWdata[13:8];
  assign wrPtr      = ctlWdata[21:16];
  assign invNow     = ctlWe && ctlWdata[2];
  assign ptrInRange = ptrQ < NUM_SLOTS;
  assign ptrNext    = (ptrQ >= LAST_SLOT) ? lockQ : ptrQ + 1'b1;
  assign unusedBits = ^{ctlWdata[31:22], ctlWdata[15:14], ctlWdata[7:4]};

  assign strobe.invAll   = invNow;
  assign strobe.refill   = refWe && !invNow && ptrInRange;
  assign strobe.xlateEn  = enQ;
  assign strobe.sharedVm = sharedQ;
  assign wrIdx           = ptrQ[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enQ     <= 1'b0;
      sharedQ <= 1'b0;
      nfQ     <= 1'b0;
      lockQ   <= '0;
      ptrQ    <= '0;
    end else if (ctlWe) begin
      enQ     <= ctlWdata[0];
      sharedQ <= ctlWdata[1];
      nfQ     <= ctlWdata[3] | missSeen;
      lockQ   <= wrLock;
      ptrQ    <= invNow ? wrLock : wrPtr;
    end else begin
      nfQ <= nfQ | missSeen;
      if (strobe.refill) ptrQ <= ptrNext;
    end
  end

  assign ctlRdata = {10'b0, ptrQ, 2'b0, lockQ, 4'b0, nfQ, 1'b0, sharedQ, enQ};

  AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.refill && !ctlWe) |=>
      (ptrQ == $past(ptrQ) + 1'b1) || (ptrQ == $past(lockQ))); // R10
  AST_MISS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    missSeen |=> ctlRdata[3]); // R6
  AST_PTR_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.refill && !ctlWe && lockQ < NUM_SLOTS) |=> (ptrQ < NUM_SLOTS)); // R10
endmodule

// File: rtl/segTlbData.sv
module segTlbData
  import segTlbPkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       strobe,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic [31:0]      refHi,
  input  logic [31:0]      refLo,
  input  logic             lkValid,
  input  logic [31:0]      lkVaddr,
  input  logic [1:0]       lkAccess,
  input  logic             lkPriv,
  input  logic [7:0]       curAsid,
  output logic             missSeen,
  output logic             rsValid,
  output logic [2:0]       rsStatus,
  output logic [31:0]      rsPaddr,
  output logic             rsCacheable
);
  tlbEntry_t        entQ [ENTRIES];
  tlbEntry_t        newEnt, selEnt;
  logic [ENTRIES-1:0] matchVec, validVec;
  logic             found, isExec, translatedSeg, userOk, permOk;
  logic [2:0]       seg, resNext;
  logic [31:0]      paNext, selMask;
  logic             cNext;
  logic             unusedBits;

  assign newEnt = '{vpn: refHi[31:10], valid: refHi[9], instr: refHi[8], asid: refHi[7:0],
                    pfn: refLo[31:10], cach: refLo[9], glob: refLo[8], ap: refLo[6:4],
                    sz: refLo[3:2], dirty: refLo[1]};
  assign unusedBits = refLo[7] ^ refLo[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) entQ[i] <= '0;
    end else if (strobe.invAll) begin
      for (int i = 0; i < ENTRIES; i++) entQ[i].valid <= 1'b0;
    end else if (strobe.refill) begin
      entQ[wrIdx] <= newEnt;
    end
  end

  assign isExec = (lkAccess == ACC_EXEC);

  for (genvar g = 0; g < ENTRIES; g++) begin : gMatch
    logic [31:0] pgMask;
    logic        pageHit, asidOk;
    assign pgMask      = offMask(entQ[g].sz);
    assign pageHit     = ((entQ[g].vpn ^ lkVaddr[31:10]) & ~pgMask[31:10]) == '0;
    assign asidOk      = entQ[g].glob || strobe.sharedVm || (entQ[g].asid == curAsid);
    assign validVec[g] = entQ[g].valid;
    assign matchVec[g] = entQ[g].valid && pageHit && asidOk && (entQ[g].instr == isExec);
  end

  always_comb begin
    found  = 1'b0;
    selEnt = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (matchVec[i] && !found) begin
        found  = 1'b1;
        selEnt = entQ[i];
      end
    end
  end

  assign seg           = lkVaddr[31:29];
  assign translatedSeg = !lkVaddr[31] || (seg == 3'b110);
  assign selMask       = offMask(selEnt.sz);
  assign userOk        = lkPriv || selEnt.ap[2];

  always_comb begin
    case (lkAccess)
      ACC_WRITE: permOk = userOk && selEnt.ap[1];
      ACC_EXEC:  permOk = userOk && selEnt.ap[0];
      default:   permOk = userOk;
    endcase
  end

  always_comb begin
    resNext = RES_HIT;
    paNext  = lkVaddr;
    cNext   = 1'b0;
    if (!lkPriv && lkVaddr[31]) begin
      resNext = RES_ACCERR;
      paNext  = '0;
    end else if (!translatedSeg) begin
      cNext = (seg == 3'b100);
    end else if (!strobe.xlateEn) begin
      cNext = 1'b1;
    end else if (!found) begin
      resNext = RES_MISS;
      paNext  = '0;
    end else if (!permOk) begin
      resNext = RES_PERM;
      paNext  = '0;
    end else if (lkAccess == ACC_WRITE && !selEnt.dirty) begin
      resNext = RES_DIRTY;
      paNext  = '0;
    end else begin
      paNext = ({selEnt.pfn, 10'b0} & ~selMask) | (lkVaddr & selMask);
      cNext  = selEnt.cach;
    end
  end

  assign missSeen = lkValid && (resNext == RES_MISS);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rsValid     <= 1'b0;
      rsStatus    <= RES_HIT;
      rsPaddr     <= '0;
      rsCacheable <= 1'b0;
    end else begin
      rsValid <= lkValid;
      if (lkValid) begin
        rsStatus    <= resNext;
        rsPaddr     <= paNext;
        rsCacheable <= cNext;
      end
    end
  end

  AST_UNPRIV_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (lkValid && !lkPriv && lkVaddr[31]) |=> (rsStatus == RES_ACCERR)); // R2
  AST_FIXED_SEG: assert property (@(posedge clk) disable iff (!rstN)
    (lkValid && lkPriv && lkVaddr[31] && lkVaddr[31:29] != 3'b110) |=>
      (rsStatus == RES_HIT && rsPaddr == $past(lkVaddr))); // R1
  AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    lkValid |-> $onehot0(matchVec)); // R4
  AST_INV_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.invAll |=> (validVec == '0)); // R11
  AST_RESULT_VALID: assert property (@(posedge clk) disable iff (!rstN)
    lkValid |=> rsValid); // R12
endmodule

// File: rtl/segTlb.sv
module segTlb
  import segTlbPkg::*;
#(
  parameter int ENTRIES = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        ctlWe,
  input  logic [31:0] ctlWdata,
  output logic [31:0] ctlRdata,
  input  logic        refWe,
  input  logic [31:0] refHi,
  input  logic [31:0] refLo,
  input  logic        lkValid,
  input  logic [31:0] lkVaddr,
  input  logic [1:0]  lkAccess,
  input  logic        lkPriv,
  input  logic [7:0]  curAsid,
  output logic        rsValid,
  output logic [2:0]  rsStatus,
  output logic [31:0] rsPaddr,
  output logic        rsCacheable
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  ctlStrobe_t       strobe;
  logic [IDX_W-1:0] wrIdx;
  logic             missSeen;

  segTlbCtrl #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) uCtrl (
    .clk(clk), .rstN(rstN), .ctlWe(ctlWe), .ctlWdata(ctlWdata), .refWe(refWe),
    .missSeen(missSeen), .strobe(strobe), .wrIdx(wrIdx), .ctlRdata(ctlRdata)
  );

  segTlbData #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrIdx(wrIdx), .refHi(refHi), .refLo(refLo),
    .lkValid(lkValid), .lkVaddr(lkVaddr), .lkAccess(lkAccess), .lkPriv(lkPriv),
    .curAsid(curAsid), .missSeen(missSeen), .rsValid(rsValid), .rsStatus(rsStatus),
    .rsPaddr(rsPaddr), .rsCacheable(rsCacheable)
  );
endmodule

// File: tb/tb_segTlb.sv
module tb_segTlb;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] HIT = 3'd0, MISS = 3'd1, AERR = 3'd2, PERM = 3'd3, DIRT = 3'd4;
  localparam logic [1:0] RD = 2'd0, WR = 2'd1, EX = 2'd2;

  logic clk = 1'b0, rstN = 1'b0;
  logic ctlWe = 1'b0, refWe = 1'b0, lkValid = 1'b0, lkPriv = 1'b0;
  logic [31:0] ctlWdata = '0, refHi = '0, refLo = '0, lkVaddr = '0;
  logic [1:0] lkAccess = '0;
  logic [7:0] curAsid = '0;
  logic [31:0] ctlRdata, rsPaddr;
  logic rsValid, rsCacheable;
  logic [2:0] rsStatus;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  segTlb dut (.*);

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mkHi(input logic [31:0] va, input logic [7:0] asid, input logic instr);
    return {va[31:10], 1'b1, instr, asid};
  endfunction
  function automatic logic [31:0] mkLo(input logic [31:0] pa, input logic c, input logic g,
                                       input logic [2:0] ap, input logic [1:0] sz, input logic d);
    return {pa[31:10], c, g, 1'b0, ap, sz, d, 1'b0};
  endfunction

  task automatic ctlWrite(input logic en, input logic sh, input logic inv, input logic nf,
                          input logic [5:0] lock, input logic [5:0] ptr);
    @(negedge clk);
    ctlWe = 1'b1;
    ctlWdata = {10'b0, ptr, 2'b0, lock, 4'b0, nf, inv, sh, en};
    @(negedge clk);
    ctlWe = 1'b0;
  endtask

  task automatic refill(input logic [31:0] hi, input logic [31:0] lo);
    @(negedge clk);
    refWe = 1'b1; refHi = hi; refLo = lo;
    @(negedge clk);
    refWe = 1'b0;
  endtask

  task automatic expLk(input string tag, input logic [31:0] va, input logic [1:0] acc,
                       input logic priv, input logic [7:0] asid,
                       input logic [2:0] st, input logic [31:0] pa, input logic c);
    @(negedge clk);
    lkValid = 1'b1; lkVaddr = va; lkAccess = acc; lkPriv = priv; curAsid = asid;
    @(negedge clk);
    lkValid = 1'b0;
    chk(tag, "valid", {31'b0, rsValid}, 32'd1);
    chk(tag, "status", {29'b0, rsStatus}, {29'b0, st});
    chk(tag, "paddr", rsPaddr, pa);
    chk(tag, "cacheable", {31'b0, rsCacheable}, {31'b0, c});
  endtask

  task automatic tReset();
    chk("R6", "ctl after reset", ctlRdata, 32'h0);
    chk("R12", "rsValid after reset", {31'b0, rsValid}, 32'd0);
  endtask

  task automatic tSegments();
    expLk("R1", 32'h8000_1234, RD, 1'b1, 8'd0, HIT, 32'h8000_1234, 1'b1);
    expLk("R1", 32'hA000_0010, WR, 1'b1, 8'd0, HIT, 32'hA000_0010, 1'b0);
    expLk("R1", 32'hE000_0F00, EX, 1'b1, 8'd0, HIT, 32'hE000_0F00, 1'b0);
  endtask

  task automatic tUnpriv();
    expLk("R2", 32'h8000_0000, RD, 1'b0, 8'd0, AERR, 32'h0, 1'b0);
    expLk("R2", 32'hC000_1000, WR, 1'b0, 8'd0, AERR, 32'h0, 1'b0);
  endtask

  task automatic tDisabled();
    expLk("R3", 32'h1234_5678, RD, 1'b1, 8'd0, HIT, 32'h1234_5678, 1'b1);
    expLk("R3", 32'hC000_0040, WR, 1'b1, 8'd0, HIT, 32'hC000_0040, 1'b1);
  endtask

  task automatic tMiss();
    ctlWrite(1'b1, 1'b0, 1'b0, 1'b0, 6'd0, 6'd0);
    expLk("R6", 32'h0040_3ABC, RD, 1'b1, 8'd5, MISS, 32'h0, 1'b0);
    chk("R6", "not-found set", {31'b0, ctlRdata[3]}, 32'd1);
    ctlWrite(1'b1, 1'b0, 1'b0, 1'b0, 6'd0, 6'd0);
    chk("R6", "not-found cleared", {31'b0, ctlRdata[3]}, 32'd0);
  endtask

  task automatic loadEntries();
    refill(mkHi(32'h0040_3000, 8'd5, 1'b0), mkLo(32'h1234_5000, 1'b1, 1'b0, 3'b111, 2'd1, 1'b1));
    refill(mkHi(32'h0500_0000, 8'd5, 1'b0), mkLo(32'h0A00_0000, 1'b1, 1'b0, 3'b111, 2'd3, 1'b1));
    refill(mkHi(32'h0600_0000, 8'd5, 1'b0), mkLo(32'h0B00_0000, 1'b0, 1'b0, 3'b111, 2'd2, 1'b1));
    refill(mkHi(32'h0700_0400, 8'd5, 1'b0), mkLo(32'h0C00_0800, 1'b1, 1'b0, 3'b111, 2'd0, 1'b1));
    refill(mkHi(32'h0800_0000, 8'd9, 1'b0), mkLo(32'h0D00_0000, 1'b1, 1'b1, 3'b111, 2'd1, 1'b1));
    refill(mkHi(32'hC000_1000, 8'd5, 1'b0), mkLo(32'h2000_1000, 1'b1, 1'b0, 3'b111, 2'd1, 1'b1));
    refill(mkHi(32'h0100_0000, 8'd5, 1'b0), mkLo(32'h3100_0000, 1'b1, 1'b0, 3'b010, 2'd1, 1'b1));
    refill(mkHi(32'h0200_0000, 8'd5, 1'b1), mkLo(32'h3200_0000, 1'b1, 1'b0, 3'b001, 2'd1, 1'b1));
    refill(mkHi(32'h0300_0000, 8'd5, 1'b0), mkLo(32'h3300_0000, 1'b1, 1'b0, 3'b100, 2'd1, 1'b0));
    refill(mkHi(32'h0300_4000, 8'd5, 1'b0), mkLo(32'h3300_4000, 1'b1, 1'b0, 3'b110, 2'd1, 1'b0));
    chk("R10", "pointer after 10 refills", {26'b0, ctlRdata[21:16]}, 32'd10);
  endtask

  task automatic tMatch();
    expLk("R4", 32'h0040_3ABC, RD, 1'b1, 8'd5, HIT, 32'h1234_5ABC, 1'b1);
    expLk("R4", 32'h0040_3ABC, RD, 1'b1, 8'd6, MISS, 32'h0, 1'b0);
    ctlWrite(1'b1, 1'b1, 1'b0, 1'b0, 6'd0, 6'd10);
    expLk("R4", 32'h0040_3ABC, RD, 1'b1, 8'd6, HIT, 32'h1234_5ABC, 1'b1);
    ctlWrite(1'b1, 1'b0, 1'b0, 1'b0, 6'd0, 6'd10);
    expLk("R4", 32'h0800_0123, RD, 1'b1, 8'h33, HIT, 32'h0D00_0123, 1'b1);
    expLk("R4", 32'h0200_0010, EX, 1'b1, 8'd5, HIT, 32'h3200_0010, 1'b1);
    expLk("R4", 32'h0200_0010, RD, 1'b1, 8'd5, MISS, 32'h0, 1'b0);
  endtask

  task automatic tSizes();
    expLk("R5", 32'h050A_BCDE, RD, 1'b1, 8'd5, HIT, 32'h0A0A_BCDE, 1'b1);
    expLk("R5", 32'h0600_F123, RD, 1'b1, 8'd5, HIT, 32'h0B00_F123, 1'b0);
    expLk("R5", 32'h0700_07FF, RD, 1'b1, 8'd5, HIT, 32'h0C00_0BFF, 1'b1);
    expLk("R5", 32'h0700_0800, RD, 1'b1, 8'd5, MISS, 32'h0, 1'b0);
    expLk("R5", 32'hC000_1FFC, WR, 1'b1, 8'd5, HIT, 32'h2000_1FFC, 1'b1);
  endtask

  task automatic tPerm();
    expLk("R7", 32'h0100_0044, RD, 1'b1, 8'd5, HIT, 32'h3100_0044, 1'b1);
    expLk("R7", 32'h0100_0044, WR, 1'b1, 8'd5, HIT, 32'h3100_0044, 1'b1);
    expLk("R7", 32'h0300_0008, WR, 1'b1, 8'd5, PERM, 32'h0, 1'b0);
    expLk("R8", 32'h0100_0044, RD, 1'b0, 8'd5, PERM, 32'h0, 1'b0);
    expLk("R8", 32'h0200_0010, EX, 1'b0, 8'd5, PERM, 32'h0, 1'b0);
    expLk("R8", 32'h0300_0008, RD, 1'b0, 8'd5, HIT, 32'h3300_0008, 1'b1);
    expLk("R8", 32'h0300_0008, WR, 1'b0, 8'd5, PERM, 32'h0, 1'b0);
    expLk("R9", 32'h0300_4010, WR, 1'b1, 8'd5, DIRT, 32'h0, 1'b0);
    expLk("R9", 32'h0300_4010, WR, 1'b0, 8'd5, DIRT, 32'h0, 1'b0);
    expLk("R9", 32'h0300_4010, RD, 1'b0, 8'd5, HIT, 32'h3300_4010, 1'b1);
  endtask

  task automatic tLookupWithRefill();
    @(negedge clk);
    lkValid = 1'b1; lkVaddr = 32'h0900_0020; lkAccess = RD; lkPriv = 1'b1; curAsid = 8'd5;
    refWe = 1'b1; refHi = mkHi(32'h0900_0000, 8'd5, 1'b0);
    refLo = mkLo(32'h3900_0000, 1'b1, 1'b0, 3'b111, 2'd1, 1'b1);
    @(negedge clk);
    lkValid = 1'b0; refWe = 1'b0;
    chk("R12", "same-cycle lookup sees old table", {29'b0, rsStatus}, {29'b0, MISS});
    expLk("R12", 32'h0900_0020, RD, 1'b1, 8'd5, HIT, 32'h3900_0020, 1'b1);
  endtask

  task automatic tInvalidate();
    ctlWrite(1'b1, 1'b0, 1'b1, 1'b0, 6'd0, 6'd7);
    chk("R11", "invalidate reads 0", {31'b0, ctlRdata[2]}, 32'd0);
    chk("R11", "pointer to lockdown", {26'b0, ctlRdata[21:16]}, 32'd0);
    expLk("R11", 32'h0040_3ABC, RD, 1'b1, 8'd5, MISS, 32'h0, 1'b0);
    expLk("R11", 32'h0900_0020, RD, 1'b1, 8'd5, MISS, 32'h0, 1'b0);
    refill(mkHi(32'h0A00_0000, 8'd5, 1'b0), mkLo(32'h3A00_0000, 1'b1, 1'b0, 3'b111, 2'd1, 1'b1));
    @(negedge clk);
    ctlWe = 1'b1; ctlWdata = {10'b0, 6'd0, 2'b0, 6'd1, 4'b0, 1'b0, 1'b1, 1'b0, 1'b1};
    refWe = 1'b1; refHi = mkHi(32'h0B00_0000, 8'd5, 1'b0);
    refLo = mkLo(32'h3B00_0000, 1'b1, 1'b0, 3'b111, 2'd1, 1'b1);
    @(negedge clk);
    ctlWe = 1'b0; refWe = 1'b0;
    chk("R11", "pointer after invalidate+refill", {26'b0, ctlRdata[21:16]}, 32'd1);
    expLk("R11", 32'h0B00_0000, RD, 1'b1, 8'd5, MISS, 32'h0, 1'b0);
    expLk("R11", 32'h0A00_0000, RD, 1'b1, 8'd5, MISS, 32'h0, 1'b0);
  endtask

  task automatic tLockdown();
    ctlWrite(1'b1, 1'b0, 1'b1, 1'b0, 6'd0, 6'd0);
    refill(mkHi(32'h0E00_0000, 8'd5, 1'b0), mkLo(32'h4E00_0000, 1'b1, 1'b0, 3'b111, 2'd1, 1'b1));
    refill(mkHi(32'h0F00_0000, 8'd5, 1'b0), mkLo(32'h4F00_0000, 1'b1, 1'b0, 3'b111, 2'd1, 1'b1));
    ctlWrite(1'b1, 1'b0, 1'b0, 1'b0, 6'd2, 6'd2);
    for (int i = 0; i < 14; i++)
      refill(mkHi(32'h1000_0000 + 32'(i) * 32'h1000, 8'd5, 1'b0),
             mkLo(32'h5000_0000 + 32'(i) * 32'h1000, 1'b1, 1'b0, 3'b111, 2'd1, 1'b1));
    chk("R10", "pointer wrapped to lockdown", {26'b0, ctlRdata[21:16]}, 32'd2);
    refill(mkHi(32'h1000_E000, 8'd5, 1'b0), mkLo(32'h5000_E000, 1'b1, 1'b0, 3'b111, 2'd1, 1'b1));
    chk("R10", "pointer after wrap refill", {26'b0, ctlRdata[21:16]}, 32'd3);
    expLk("R10", 32'h1000_0004, RD, 1'b1, 8'd5, MISS, 32'h0, 1'b0);
    expLk("R10", 32'h1000_E004, RD, 1'b1, 8'd5, HIT, 32'h5000_E004, 1'b1);
    expLk("R10", 32'h1000_1004, RD, 1'b1, 8'd5, HIT, 32'h5000_1004, 1'b1);
    expLk("R10", 32'h0E00_0004, RD, 1'b1, 8'd5, HIT, 32'h4E00_0004, 1'b1);
    expLk("R10", 32'h0F00_0004, RD, 1'b1, 8'd5, HIT, 32'h4F00_0004, 1'b1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R12 watchdog act=running exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tSegments();
    tUnpriv();
    tDisabled();
    tMiss();
    loadEntries();
    tMatch();
    tSizes();
    tPerm();
    tLookupWithRefill();
    tInvalidate();
    tLockdown();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule